// File: doc/BRIEF.md
# Variable Pulse Width Serial Frame Transmitter

This block sends one message at a time onto a single-wire, wired-OR serial bus using variable pulse width signalling. A host first writes the message bytes into a small internal buffer, one byte per write, and supplies the number of data bytes. It then pulses a start strobe. The block drives a long active start symbol and sends every data bit as a timed pulse. The pulse level alternates from bit to bit, and the pulse duration together with its level carries the bit value. After the last data bit the block appends an inverted CRC-8 byte. The frame closes with a long passive interval that covers the end-of-data and end-of-frame gaps.

All symbol timing comes from a microsecond clock enable, which is derived from the system clock by a parameterised prescaler. While the block drives a passive bit, it reads the bus level back. If that level is active, another node has won the bus: the block stops at once, releases the line and raises a lost-arbitration flag. A frame is rejected, and an error flag is raised, when the requested length is zero or when the data bytes plus the CRC byte would exceed the frame limit.

Top module: `vpw_tx`

## Requirements
- R1: After reset `bus_out` is 0 (passive), and `busy`, `done`, `len_err` and `arb_lost` are all 0. Whenever `busy` is 0, `bus_out` is 0.
- R2: A `start` pulse while idle with `msg_len` in 1..MAX_BYTES-1 is accepted. In the next cycle `busy` is 1 and `bus_out` is 1 (active), and the active start symbol lasts exactly T_SOF_US×CLKS_PER_US clocks.
- R3: After the start symbol the block sends the buffer bytes at indices 0 to `msg_len`-1 in index order, then the CRC byte, each byte most significant bit first. The first bit is passive (`bus_out`=0) and the level inverts on every following bit, so each frame has 8×(`msg_len`+1) bit pulses.
- R4: A bit pulse lasts T_SHORT_US×CLKS_PER_US clocks for an active 1 or a passive 0. It lasts T_LONG_US×CLKS_PER_US clocks for an active 0 or a passive 1.
- R5: The CRC byte covers only the data bits, not the start symbol. It uses polynomial 0x1D (x^8+x^4+x^3+x^2+1), starts from 0xFF and is sent bitwise inverted.
- R6: After the last CRC bit, `bus_out` stays 0 for exactly T_EOF_US×CLKS_PER_US clocks (the end-of-data gap of T_EOD_US inside it). `busy` then falls, and `done` is 1 for exactly one cycle.
- R7: A `start` pulse while idle with `msg_len` of 0 or more than MAX_BYTES-1 sends nothing and sets `len_err` in the next cycle. The next accepted start clears `len_err`.
- R8: During a bit pulse in which `bus_out` is 0, a 1 on `bus_in` ends the frame. In the next cycle `busy` is 0, `bus_out` is 0, `arb_lost` is 1 and `done` is 1. A 1 on `bus_in` while `bus_out` is 1 has no effect. The next accepted start clears `arb_lost`.
- R9: While `busy` is 1, `start` pulses and buffer writes are ignored, and the frame on the bus is unchanged by them.
- R10: A frame with the maximum of MAX_BYTES-1 data bytes is sent complete, with its CRC byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one message byte into the buffer (idle only) |
| wr_addr | input | $clog2(MAX_BYTES) | Buffer index of the byte being written |
| wr_data | input | 8 | Message byte to write |
| msg_len | input | $clog2(MAX_BYTES) | Number of data bytes to send, sampled at start |
| start | input | 1 | Start strobe, one cycle |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse when a frame ends or is abandoned |
| len_err | output | 1 | Last start request had an illegal length |
| arb_lost | output | 1 | Last frame was abandoned on a bus mismatch |
| bus_in | input | 1 | Bus level read back, 1 = active |
| bus_out | output | 1 | Bus drive, 1 = active |

## Verification
Every fault in this block shows up as a pulse of the wrong level or wrong length on `bus_out`. A wrong bit counter, shift register or level toggle therefore appears within one long symbol (T_LONG_US microseconds) of the point where it goes wrong. A corrupted CRC register affects only the last eight pulses, so the bench decodes the whole pulse train back into levels and durations and compares it against a reference built from the message bytes. A missed or late abort shows at `busy` and `arb_lost` one cycle after the bench drives the bus active under a passive bit.

// File: rtl/vpw_tx_pkg.sv
package vpw_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SOF,
      ST_BITS,
      ST_EOD,
      ST_EOF
   } vpw_state_t;

   localparam logic [7:0] CRC_POLY = 8'h1D;
   localparam logic [7:0] CRC_SEED = 8'hFF;

   // one serial CRC step, message bit enters at the top
   function automatic logic [7:0] crc8_next(input logic [7:0] cur, input logic din);
      logic fb;
      fb = cur[7] ^ din;
      return {cur[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
   endfunction

endpackage

// File: rtl/vpw_us_tick.sv
module vpw_us_tick #(
   parameter int CLKS_PER_US = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);

   generate
      if (CLKS_PER_US < 1) begin : g_bad_div
         $error("vpw_us_tick: CLKS_PER_US must be at least 1");
      end

      if (CLKS_PER_US == 1) begin : g_direct
         logic unused_in;
         assign unused_in = clr ^ rst_n ^ clk;
         assign tick = 1'b1;
      end else begin : g_div
         localparam int PW = $clog2(CLKS_PER_US);
         localparam logic [PW-1:0] LAST = PW'(CLKS_PER_US - 1);
         logic [PW-1:0] pre;

         always_ff @(posedge clk) begin
            if (!rst_n)          pre <= '0;
            else if (clr)        pre <= '0;
            else if (pre == LAST) pre <= '0;
            else                 pre <= pre + 1'b1;
         end

         assign tick = (pre == LAST);

         // R4: ticks are spaced, never back to back when dividing
         assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !clr) |=> !tick);
      end
   endgenerate

endmodule

// File: rtl/vpw_sym_timer.sv
module vpw_sym_timer #(
   parameter int TW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   input  logic          tick,
   output logic          expire
);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)                  cnt <= '0;
      else if (load)               cnt <= load_val;
      else if (tick && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expire = tick && (cnt == '0);

   // R4: the count never rises except through a load
   assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(load) |-> (cnt <= $past(cnt)));

endmodule

// File: rtl/vpw_msg_buf.sv
module vpw_msg_buf #(
   parameter int DEPTH = 11,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_addr,
   output logic [7:0]       rd_data
);

   generate
      if (DEPTH < 1 || DEPTH >= (1 << IDX_W)) begin : g_bad_depth
         $error("vpw_msg_buf: DEPTH does not fit the index width");
      end
   endgenerate

   logic [7:0] slot [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n)                                   slot[g] <= 8'h00;
         else if (wr_en && wr_addr == IDX_W'(g))       slot[g] <= wr_data;
      end
   end

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < DEPTH; i++) begin
         if (rd_addr == IDX_W'(i)) rd_data = slot[i];
      end
   end

endmodule

// File: rtl/vpw_tx.sv
module vpw_tx
   import vpw_tx_pkg::*;
#(
   parameter int CLKS_PER_US = 8,
   parameter int MAX_BYTES   = 12,
   parameter int T_SHORT_US  = 64,
   parameter int T_LONG_US   = 128,
   parameter int T_SOF_US    = 200,
   parameter int T_EOD_US    = 200,
   parameter int T_EOF_US    = 280
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [$clog2(MAX_BYTES)-1:0] wr_addr,
   input  logic [7:0]                   wr_data,
   input  logic [$clog2(MAX_BYTES)-1:0] msg_len,
   input  logic                         start,
   output logic                         busy,
   output logic                         done,
   output logic                         len_err,
   output logic                         arb_lost,
   input  logic                         bus_in,
   output logic                         bus_out
);

   localparam int IDX_W  = $clog2(MAX_BYTES);
   localparam int DEPTH  = MAX_BYTES - 1;
   localparam int T_TAIL = T_EOF_US - T_EOD_US;
   localparam int T_M1   = (T_SOF_US > T_LONG_US) ? T_SOF_US : T_LONG_US;
   localparam int T_MAX  = (T_M1 > T_EOF_US) ? T_M1 : T_EOF_US;
   localparam int TW     = $clog2(T_MAX + 1);

   generate
      if (MAX_BYTES < 2) begin : g_bad_len
         $error("vpw_tx: MAX_BYTES must allow one data byte plus CRC");
      end
      if (T_SHORT_US < 1 || T_SHORT_US >= T_LONG_US) begin : g_bad_sym
         $error("vpw_tx: short symbol must be nonzero and shorter than long");
      end
      if (T_EOD_US < 1 || T_EOD_US >= T_EOF_US) begin : g_bad_tail
         $error("vpw_tx: end-of-data gap must be inside end-of-frame gap");
      end
   endgenerate

   vpw_state_t       state;
   logic [7:0]       sh, crc, rd_data, new_byte;
   logic [2:0]       bitn;
   logic [IDX_W-1:0] byte_idx, len_q;
   logic             in_crc, new_in_crc, byte_edge, bit_val, lvl, data_bit;
   logic             end_bits, lose, len_ok, start_ok, start_bad, idle;
   logic             tick, expire, tmr_load;
   logic [TW-1:0]    dur, tmr_val;

   assign idle      = (state == ST_IDLE);
   assign busy      = !idle;
   assign len_ok    = (msg_len != '0) && (msg_len <= IDX_W'(DEPTH));
   assign start_ok  = start && idle && len_ok;
   assign start_bad = start && idle && !len_ok;
   assign end_bits  = (state == ST_BITS) && (bitn == 3'd7) && in_crc;
   assign lose      = (state == ST_BITS) && !bus_out && bus_in;

   vpw_us_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(start_ok), .tick(tick)
   );

   vpw_sym_timer #(.TW(TW)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .tick(tick), .expire(expire)
   );

   vpw_msg_buf #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en && idle), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(byte_idx), .rd_data(rd_data)
   );

   // next bit to put on the wire and its pulse length
   always_comb begin
      new_byte   = rd_data;
      new_in_crc = 1'b0;
      if (state == ST_BITS && byte_idx == len_q) begin
         new_byte   = ~crc;
         new_in_crc = 1'b1;
      end
      byte_edge = (state == ST_SOF) || (bitn == 3'd7);
      bit_val   = byte_edge ? new_byte[7] : sh[6];
      data_bit  = byte_edge ? !new_in_crc : !in_crc;
      lvl       = !bus_out;
      dur       = (bit_val ^ lvl) ? TW'(T_LONG_US - 1) : TW'(T_SHORT_US - 1);
   end

   always_comb begin
      case (state)
         ST_IDLE: tmr_val = TW'(T_SOF_US - 1);
         ST_SOF:  tmr_val = dur;
         ST_BITS: tmr_val = end_bits ? TW'(T_EOD_US - 1) : dur;
         ST_EOD:  tmr_val = TW'(T_TAIL - 1);
         default: tmr_val = '0;
      endcase
   end

   assign tmr_load = start_ok || (expire && !idle);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bus_out  <= 1'b0;
         done     <= 1'b0;
         len_err  <= 1'b0;
         arb_lost <= 1'b0;
         sh       <= 8'h00;
         crc      <= CRC_SEED;
         bitn     <= 3'd0;
         byte_idx <= '0;
         len_q    <= '0;
         in_crc   <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start_ok) begin
                  state    <= ST_SOF;
                  bus_out  <= 1'b1;
                  byte_idx <= '0;
                  len_q    <= msg_len;
                  crc      <= CRC_SEED;
                  in_crc   <= 1'b0;
                  len_err  <= 1'b0;
                  arb_lost <= 1'b0;
               end else if (start_bad) begin
                  len_err  <= 1'b1;
               end
            end
            ST_SOF: begin
               if (expire) begin
                  state    <= ST_BITS;
                  bus_out  <= lvl;
                  sh       <= new_byte;
                  bitn     <= 3'd0;
                  byte_idx <= byte_idx + 1'b1;
                  in_crc   <= 1'b0;
                  crc      <= crc8_next(crc, bit_val);
               end
            end
            ST_BITS: begin
               if (lose) begin
                  state    <= ST_IDLE;
                  bus_out  <= 1'b0;
                  arb_lost <= 1'b1;
                  done     <= 1'b1;
               end else if (expire) begin
                  if (end_bits) begin
                     state   <= ST_EOD;
                     bus_out <= 1'b0;
                  end else begin
                     bus_out <= lvl;
                     if (data_bit) crc <= crc8_next(crc, bit_val);
                     if (bitn == 3'd7) begin
                        sh     <= new_byte;
                        bitn   <= 3'd0;
                        in_crc <= new_in_crc;
                        if (!new_in_crc) byte_idx <= byte_idx + 1'b1;
                     end else begin
                        sh   <= {sh[6:0], 1'b0};
                        bitn <= bitn + 1'b1;
                     end
                  end
               end
            end
            ST_EOD: begin
               if (expire) state <= ST_EOF;
            end
            default: begin
               if (expire) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end
            end
         endcase
      end
   end

   // R1: the line is released whenever no frame is running
   assert_idle_passive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !bus_out);

   // R2: an accepted start drives the line active at once
   assert_sof_begin_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok |=> (busy && bus_out));

   // R3: every bit boundary inside the frame inverts the line
   assert_level_flip_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BITS && expire && !end_bits && !lose) |=> (bus_out != $past(bus_out)));

   // R6: done only as the block returns to idle, for one cycle
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R7: an illegal length never starts a frame
   assert_len_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_bad |=> (len_err && !busy));

   // R8: a mismatch under a passive bit abandons the frame
   assert_arb_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lose |=> (!busy && arb_lost && !bus_out && done));

   // R9: a running frame keeps its length and state against a new start
   assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !lose && !expire) |=> (busy && $stable(len_q)));

endmodule

// File: tb/vpw_tx_test.sv
module vpw_tx_test;

   localparam int C    = 2;
   localparam int MAXB = 12;
   localparam int IW   = 4;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic          rst_n, wr_en, start, rival;
   logic [IW-1:0] wr_addr, msg_len;
   logic [7:0]    wr_data;
   logic          busy, done, len_err, arb_lost, bus_out, bus_in;

   assign bus_in = bus_out | rival;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   vpw_tx #(.CLKS_PER_US(C), .MAX_BYTES(MAXB)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .msg_len(msg_len), .start(start), .busy(busy),
      .done(done), .len_err(len_err), .arb_lost(arb_lost),
      .bus_in(bus_in), .bus_out(bus_out)
   );

   // stimulus table: {data byte count, bytes with index 0 in the low byte}
   localparam int NVEC = 5;
   localparam logic [91:0] VEC [NVEC] = '{
      {4'd1,  88'h3C},
      {4'd2,  88'h0FF0},
      {4'd3,  88'h8100FF},
      {4'd5,  88'h123456789A},
      {4'd11, 88'hDEADBEEF0123456789ABCD}
   };

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   function automatic logic [7:0] ref_crc(input int len, input logic [87:0] d);
      logic [7:0] c;
      logic       fb;
      c = 8'hFF;
      for (int i = 0; i < len; i++) begin
         for (int b = 7; b >= 0; b--) begin
            fb = c[7] ^ d[8*i + b];
            c  = {c[6:0], 1'b0} ^ (fb ? 8'h1D : 8'h00);
         end
      end
      return ~c;
   endfunction

   task automatic load_msg(input int len, input logic [87:0] d);
      for (int i = 0; i < len; i++) begin
         wr_en   = 1'b1;
         wr_addr = IW'(i);
         wr_data = d[8*i +: 8];
         @(negedge clk);
      end
      wr_en   = 1'b0;
      msg_len = IW'(len);
   endtask

   int obs_lvl [128];
   int obs_len [128];
   int nrun;

   task automatic send_frame(input int len, input logic [87:0] d, input bit disturb, input string tag);
      int         cyc;
      int         cur_lvl, cur_len, nb, exp_lvl, exp_len, bad_d, bad_c;
      logic [7:0] cb;
      logic       bv;
      load_msg(len, d);
      start = 1'b1;
      @(negedge clk);
      start   = 1'b0;
      cyc     = 0;
      cur_lvl = int'(bus_out);
      cur_len = 0;
      nrun    = 0;
      while (busy && cyc < 60000) begin
         if (int'(bus_out) != cur_lvl) begin
            if (nrun < 128) begin
               obs_lvl[nrun] = cur_lvl;
               obs_len[nrun] = cur_len;
            end
            nrun++;
            cur_lvl = int'(bus_out);
            cur_len = 0;
         end
         cur_len++;
         if (disturb && cyc == 20) begin
            wr_en = 1'b1; wr_addr = '0; wr_data = ~d[7:0]; start = 1'b1;
         end
         if (disturb && cyc == 21) begin
            wr_en = 1'b0; start = 1'b0;
         end
         cyc++;
         @(negedge clk);
      end
      if (nrun < 128) begin
         obs_lvl[nrun] = cur_lvl;
         obs_len[nrun] = cur_len;
      end
      nrun++;
      chk(done === 1'b1, {tag, " R6 done pulse at frame end"}, done, 1);
      chk(busy === 1'b0, {tag, " R6 busy low after frame"}, busy, 0);
      nb = 8 * len + 8;
      cb = ref_crc(len, d);
      chk(nrun == nb + 2, {tag, " R3 pulse count"}, nrun, nb + 2);
      if (nrun == nb + 2) begin
         chk(obs_lvl[0] == 1 && obs_len[0] == 200 * C, {tag, " R2 start symbol length"},
             obs_len[0], 200 * C);
         bad_d = 0;
         bad_c = 0;
         for (int k = 0; k < nb; k++) begin
            bv      = (k < 8 * len) ? d[8 * (k / 8) + 7 - (k % 8)] : cb[7 - (k % 8)];
            exp_lvl = k % 2;
            exp_len = ((bv ^ exp_lvl[0]) ? 128 : 64) * C;
            if (obs_lvl[k + 1] != exp_lvl || obs_len[k + 1] != exp_len) begin
               if (k < 8 * len) bad_d++;
               else             bad_c++;
            end
         end
         chk(bad_d == 0, {tag, " R4 data pulse mismatches"}, bad_d, 0);
         chk(bad_c == 0, {tag, " R5 CRC pulse mismatches"}, bad_c, 0);
         chk(obs_lvl[nb + 1] == 0 && obs_len[nb + 1] == 280 * C, {tag, " R6 closing gap length"},
             obs_len[nb + 1], 280 * C);
      end
      chk(arb_lost === 1'b0, {tag, " R8 no loss on a clean bus"}, arb_lost, 0);
      chk(len_err === 1'b0, {tag, " R7 flag clear after accepted start"}, len_err, 0);
      @(negedge clk);
      chk(done === 1'b0, {tag, " R6 done lasts one cycle"}, done, 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; start = 1'b0; rival = 1'b0;
      wr_addr = '0; wr_data = '0; msg_len = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(bus_out === 1'b0, "R1 bus passive after reset", bus_out, 0);
      chk(busy === 1'b0, "R1 busy low after reset", busy, 0);
      chk(done === 1'b0 && len_err === 1'b0 && arb_lost === 1'b0, "R1 flags clear after reset",
          {done, len_err, arb_lost}, 0);

      // table walk: lengths 1 to the R10 maximum
      for (int i = 0; i < NVEC; i++) begin
         send_frame(int'(VEC[i][91:88]), VEC[i][87:0], 1'b0,
                    (VEC[i][91:88] == 4'd11) ? "R10 max frame" : $sformatf("vec%0d", i));
      end

      // R9 start and write during a frame
      send_frame(2, 88'hA55A, 1'b1, "R9 busy ignore");

      // R7 illegal lengths
      msg_len = 4'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(len_err === 1'b1, "R7 zero length flagged", len_err, 1);
      chk(busy === 1'b0 && bus_out === 1'b0, "R7 zero length sends nothing", busy, 0);
      msg_len = 4'd12;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(len_err === 1'b1, "R7 oversize length flagged", len_err, 1);
      chk(busy === 1'b0 && bus_out === 1'b0, "R7 oversize sends nothing", busy, 0);
      send_frame(1, 88'h3C, 1'b0, "R7 recover");

      // R8 arbitration
      load_msg(3, 88'h010203);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      rival = 1'b1;
      repeat (10) @(negedge clk);
      rival = 1'b0;
      @(negedge clk);
      chk(busy === 1'b1 && arb_lost === 1'b0, "R8 overlap on active has no effect", arb_lost, 0);
      while (bus_out !== 1'b0) @(negedge clk);
      rival = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0, "R8 frame abandoned", busy, 0);
      chk(arb_lost === 1'b1, "R8 loss flagged", arb_lost, 1);
      chk(bus_out === 1'b0 && done === 1'b1, "R8 line released with done", {bus_out, done}, 1);
      rival = 1'b0;
      @(negedge clk);
      send_frame(2, 88'h7E81, 1'b0, "R8 recover");

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule